// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This block is the integer multiply and divide engine of a 64-bit processor core. It takes one operation at a time: the core raises `start` with the operation selected by three control bits (divide or multiply, signed or unsigned, full 64-bit or 32-bit operands), then waits for a one-cycle `done` pulse. At that pulse a pair of results appears on `res_hi` and `res_lo`. A multiply returns the high and low halves of the product. A divide returns the remainder on `res_hi` and the quotient on `res_lo`. Both results hold their value until the next `done`.

The unit has no pipeline. A multiply takes a fixed number of cycles that depends only on operand width, because the multiplier is consumed a 16-bit digit per cycle. A divide first strips the leading zero bits of the dividend's magnitude. It then runs one restoring step per remaining significant bit, so small dividends finish early. Signed operations work on magnitudes, and the signs are restored in a final cycle. Division by zero never traps and returns a fixed result pattern.

Top module: `imdu_top`

## Requirements
- R1: After reset, `busy`, `done`, `res_hi` and `res_lo` are all zero.
- R2: A `start` sampled while the unit is idle is accepted. Counting that cycle as cycle 0, `busy` is high in cycles 1 to L-1. `done` is high for exactly cycle L, with `busy` low. A `start` in that cycle L is accepted as a new operation.
- R3: A `start` raised while `busy` is high is ignored. The running operation keeps its latency and result, and no extra `done` follows.
- R4: A 32-bit multiply (`op_div`=0, `op_wide`=0) uses only bits 31:0 of each source and takes L=4. The 64-bit product P is returned as `res_lo` = P[31:0] and `res_hi` = P[63:32], each sign-extended from its bit 31.
- R5: A 64-bit multiply (`op_div`=0, `op_wide`=1) takes L=6 and returns the 128-bit product as `res_hi`:`res_lo`.
- R6: `op_signed`=1 treats sources as two's complement and `op_signed`=0 as unsigned, for both multiply and divide.
- R7: A divide takes L = 9 + max(S, 12). S is the bit count of the dividend magnitude: the index of its highest set bit plus one, and 0 for zero. This gives 21 to 73 cycles for 64-bit and 21 to 41 cycles for 32-bit.
- R8: A divide returns the quotient truncated toward zero on `res_lo` and the remainder on `res_hi`, with the remainder carrying the dividend's sign. In 32-bit mode both results are sign-extended from bit 31.
- R9: Division by zero returns a quotient of all ones and a remainder equal to the dividend (sign-extended from bit 31 in 32-bit mode), with the latency of R7.
- R10: A signed divide of the most negative value by -1 returns that most negative value as quotient and zero as remainder.
- R11: `res_hi` and `res_lo` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new operation |
| op_div | input | 1 | 1 selects divide, 0 selects multiply |
| op_signed | input | 1 | 1 treats operands as two's complement |
| op_wide | input | 1 | 1 selects 64-bit operands, 0 selects 32-bit |
| src_a | input | 64 | Multiplicand or dividend |
| src_b | input | 64 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| res_hi | output | 64 | Product high half or remainder |
| res_lo | output | 64 | Product low half or quotient |

## Verification
The bench checks the divide latency at both ends of the skip logic. A zero dividend and a 7-bit dividend must both stop at the 21-cycle floor, while an all-ones 64-bit dividend must take the full 73 cycles. A leading-zero count that is off by one would shift every divide latency by one cycle and also misplace the quotient bits.

The sign corner cases are covered by mixed-sign divides, the most-negative-by-minus-one case and divide by zero in both widths. A design that fixed the remainder's sign from the divisor would fail on 100 / -7. A design that negated the all-ones quotient would return 1 for a negative dividend divided by zero.

32-bit multiplies are run with garbage in the upper source bits and with results that have bit 31 set. This exposes any use of the upper bits and any missing sign extension.

A start pulse during a long divide checks that the running operation is not disturbed. Back-to-back operations started in the done cycle check that the unit is free again exactly then.

// File: rtl/imdu_pkg.sv
package imdu_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_MITER = 3'd1,
        S_DPAD  = 3'd2,
        S_DNORM = 3'd3,
        S_DITER = 3'd4,
        S_FIX   = 3'd5
    } imdu_state_e;

endpackage

// File: rtl/imdu_sigbits.sv
// Significant-bit count of an unsigned value: index of the top set bit plus one.
module imdu_sigbits #(
    parameter int W  = 64,
    localparam int SW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    output logic [SW-1:0] nsig
);

    always_comb begin
        nsig = '0;
        for (int i = 0; i < W; i++) begin
            if (val[i]) nsig = SW'(i + 1);
        end
    end

endmodule

// File: rtl/imdu_mul_step.sv
// One radix-2^CHUNK multiply step: add mcand*digit into the upper half, shift right.
module imdu_mul_step #(
    parameter int XLEN  = 64,
    parameter int CHUNK = 16
) (
    input  logic [2*XLEN-1:0] acc_i,
    input  logic [XLEN-1:0]   mcand_i,
    input  logic [CHUNK-1:0]  digit_i,
    output logic [2*XLEN-1:0] acc_o
);

    logic [XLEN+CHUNK-1:0]   pp;
    logic [XLEN+CHUNK:0]     upper;
    logic [2*XLEN+CHUNK:0]   joined;

    always_comb begin
        pp     = {{CHUNK{1'b0}}, mcand_i} * {{XLEN{1'b0}}, digit_i};
        upper  = {1'b0, {CHUNK{1'b0}}, acc_i[2*XLEN-1:XLEN]} + {1'b0, pp};
        joined = {upper, acc_i[XLEN-1:0]};
        acc_o  = joined[2*XLEN+CHUNK-1:CHUNK];
    end

endmodule

// File: rtl/imdu_div_step.sv
// One restoring divide step on a partial remainder and a quotient shift register.
module imdu_div_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rem_i,
    input  logic [XLEN-1:0] quo_i,
    input  logic [XLEN-1:0] dvsr_i,
    output logic [XLEN-1:0] rem_o,
    output logic [XLEN-1:0] quo_o
);

    logic [XLEN:0]   trial;
    logic            fits;
    logic [XLEN-1:0] diff;

    always_comb begin
        trial = {rem_i, quo_i[XLEN-1]};
        fits  = (trial >= {1'b0, dvsr_i});
        diff  = trial[XLEN-1:0] - dvsr_i;
        rem_o = fits ? diff : trial[XLEN-1:0];
        quo_o = {quo_i[XLEN-2:0], fits};
    end

endmodule

// File: rtl/imdu_top.sv
module imdu_top
    import imdu_pkg::*;
#(
    parameter int XLEN         = 64,
    parameter int MUL_CHUNK    = 16,
    parameter int DIV_MIN_BITS = 12,
    parameter int DIV_PAD      = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_div,
    input  logic            op_signed,
    input  logic            op_wide,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] res_hi,
    output logic [XLEN-1:0] res_lo
);

    localparam int HALF     = XLEN / 2;
    localparam int NSTEP_W  = XLEN / MUL_CHUNK;
    localparam int NSTEP_N  = HALF / MUL_CHUNK;
    localparam int SW       = $clog2(XLEN + 1);
    localparam int CW       = $clog2(XLEN + DIV_PAD + 2) + 1;
    localparam int PAD_LOAD = (DIV_PAD > 0) ? DIV_PAD - 1 : 0;

    typedef struct packed {
        imdu_state_e      st;
        logic [CW-1:0]    cnt;
        logic             is_div;
        logic             wide;
        logic             neg_a;
        logic             neg_b;
        logic             zero_b;
        logic [XLEN-1:0]  ma;
        logic [XLEN-1:0]  mb;
        logic [XLEN-1:0]  quo;
        logic [XLEN-1:0]  rem;
        logic [2*XLEN-1:0] acc;
        logic             done;
        logic [XLEN-1:0]  hi;
        logic [XLEN-1:0]  lo;
    } imdu_regs_t;

    imdu_regs_t r_q, r_d;

    logic [SW-1:0]     sig_w;
    logic [2*XLEN-1:0] acc_nx;
    logic [XLEN-1:0]   rem_nx;
    logic [XLEN-1:0]   quo_nx;

    function automatic logic [XLEN-1:0] ext_half(input logic [XLEN-1:0] v, input logic s);
        return s ? {{HALF{v[HALF-1]}}, v[HALF-1:0]} : {{HALF{1'b0}}, v[HALF-1:0]};
    endfunction

    imdu_sigbits #(.W(XLEN)) u_sig (
        .val  (r_q.ma),
        .nsig (sig_w)
    );

    imdu_mul_step #(.XLEN(XLEN), .CHUNK(MUL_CHUNK)) u_mstep (
        .acc_i   (r_q.acc),
        .mcand_i (r_q.ma),
        .digit_i (r_q.mb[MUL_CHUNK-1:0]),
        .acc_o   (acc_nx)
    );

    imdu_div_step #(.XLEN(XLEN)) u_dstep (
        .rem_i  (r_q.rem),
        .quo_i  (r_q.quo),
        .dvsr_i (r_q.mb),
        .rem_o  (rem_nx),
        .quo_o  (quo_nx)
    );

    always_comb begin
        logic [XLEN-1:0]   ext_a, ext_b, pn, qv, rv;
        logic [2*XLEN-1:0] pw;
        logic              na, nb;
        int                nbits;

        r_d      = r_q;
        r_d.done = 1'b0;
        ext_a    = op_wide ? src_a : ext_half(src_a, op_signed);
        ext_b    = op_wide ? src_b : ext_half(src_b, op_signed);
        na       = op_signed & ext_a[XLEN-1];
        nb       = op_signed & ext_b[XLEN-1];
        pn       = '0;
        qv       = '0;
        rv       = '0;
        pw       = '0;
        nbits    = 0;

        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.is_div = op_div;
                    r_d.wide   = op_wide;
                    r_d.neg_a  = na;
                    r_d.neg_b  = nb;
                    r_d.ma     = na ? -ext_a : ext_a;
                    r_d.mb     = nb ? -ext_b : ext_b;
                    r_d.zero_b = (ext_b == '0);
                    r_d.acc    = '0;
                    r_d.rem    = '0;
                    r_d.quo    = '0;
                    if (op_div) begin
                        if (DIV_PAD > 0) begin
                            r_d.st  = S_DPAD;
                            r_d.cnt = CW'(PAD_LOAD);
                        end else begin
                            r_d.st  = S_DNORM;
                        end
                    end else begin
                        r_d.st  = S_MITER;
                        r_d.cnt = op_wide ? CW'(NSTEP_W - 1) : CW'(NSTEP_N - 1);
                    end
                end
            end
            S_MITER: begin
                r_d.acc = acc_nx;
                r_d.mb  = r_q.mb >> MUL_CHUNK;
                if (r_q.cnt == '0) r_d.st = S_FIX;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            S_DPAD: begin
                if (r_q.cnt == '0) r_d.st = S_DNORM;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            S_DNORM: begin
                nbits   = (int'(sig_w) > DIV_MIN_BITS) ? int'(sig_w) : DIV_MIN_BITS;
                r_d.quo = r_q.ma << (XLEN - nbits);
                r_d.rem = '0;
                r_d.cnt = CW'(nbits - 1);
                r_d.st  = S_DITER;
            end
            S_DITER: begin
                r_d.rem = rem_nx;
                r_d.quo = quo_nx;
                if (r_q.cnt == '0) r_d.st = S_FIX;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            S_FIX: begin
                if (!r_q.is_div) begin
                    if (r_q.wide) begin
                        pw     = (r_q.neg_a ^ r_q.neg_b) ? -r_q.acc : r_q.acc;
                        r_d.hi = pw[2*XLEN-1:XLEN];
                        r_d.lo = pw[XLEN-1:0];
                    end else begin
                        pn     = r_q.acc[XLEN+HALF-1:HALF];
                        pn     = (r_q.neg_a ^ r_q.neg_b) ? -pn : pn;
                        r_d.hi = ext_half(pn >> HALF, 1'b1);
                        r_d.lo = ext_half(pn, 1'b1);
                    end
                end else begin
                    qv = (r_q.neg_a ^ r_q.neg_b) ? -r_q.quo : r_q.quo;
                    rv = r_q.neg_a ? -r_q.rem : r_q.rem;
                    if (r_q.zero_b) begin
                        qv = '1;
                        rv = r_q.neg_a ? -r_q.ma : r_q.ma;
                    end
                    r_d.hi = r_q.wide ? rv : ext_half(rv, 1'b1);
                    r_d.lo = r_q.wide ? qv : ext_half(qv, 1'b1);
                end
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy   = (r_q.st != S_IDLE);
    assign done   = r_q.done;
    assign res_hi = r_q.hi;
    assign res_lo = r_q.lo;

endmodule

// File: rtl/imdu_chk.sv
module imdu_chk #(
    parameter int XLEN         = 64,
    parameter int MUL_CHUNK    = 16,
    parameter int DIV_MIN_BITS = 12,
    parameter int DIV_PAD      = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            op_div,
    input logic            op_wide,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] res_hi,
    input logic [XLEN-1:0] res_lo
);

    localparam int MUL_N_LAT = XLEN / 2 / MUL_CHUNK + 2;
    localparam int MUL_W_LAT = XLEN / MUL_CHUNK + 2;
    localparam int DIV_LO    = DIV_PAD + 3 + DIV_MIN_BITS;
    localparam int DIV_HI_W  = DIV_PAD + 3 + XLEN;
    localparam int DIV_HI_N  = DIV_PAD + 3 + XLEN / 2;

    logic [15:0] lat_q;
    logic        cap_div, cap_wide;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q    <= '0;
            cap_div  <= 1'b0;
            cap_wide <= 1'b0;
        end else if (start && !busy) begin
            lat_q    <= 16'd1;
            cap_div  <= op_div;
            cap_wide <= op_wide;
        end else if (busy) begin
            lat_q    <= lat_q + 16'd1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("busy during done"); // R2
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy) else $error("idle start not accepted"); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_hi) && $stable(res_lo))) else $error("result moved"); // R11
    AST_MUL32_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_div && !cap_wide) |-> (lat_q == 16'(MUL_N_LAT))) else $error("mul32 latency"); // R4
    AST_MUL64_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_div && cap_wide) |-> (lat_q == 16'(MUL_W_LAT))) else $error("mul64 latency"); // R5
    AST_DIV_LAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_div) |-> (lat_q >= 16'(DIV_LO) &&
                               lat_q <= (cap_wide ? 16'(DIV_HI_W) : 16'(DIV_HI_N))))
        else $error("divide latency out of range"); // R7

endmodule

bind imdu_top imdu_chk #(
    .XLEN(XLEN), .MUL_CHUNK(MUL_CHUNK), .DIV_MIN_BITS(DIV_MIN_BITS), .DIV_PAD(DIV_PAD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div), .op_wide(op_wide),
    .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/imdu_top_tb_top.sv
module imdu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic        op_signed = 1'b0;
    logic        op_wide = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        busy, done;
    logic [63:0] res_hi, res_lo;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    imdu_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .op_signed(op_signed), .op_wide(op_wide), .src_a(src_a), .src_b(src_b),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] sx32(logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    function automatic logic [63:0] ext_op(logic [63:0] v, bit sg, bit wd);
        if (wd) return v;
        return sg ? sx32(v) : {32'b0, v[31:0]};
    endfunction

    function automatic int sigb(logic [63:0] m);
        int s = 0;
        for (int i = 0; i < 64; i++) if (m[i]) s = i + 1;
        return s;
    endfunction

    // Reference from the requirements; results into hi, lo and expected latency.
    task automatic ref_op(bit dv, bit sg, bit wd, logic [63:0] a, logic [63:0] b,
                          output logic [63:0] hi, output logic [63:0] lo, output int lat);
        logic [63:0]  ea, eb, mag, q, r;
        logic [127:0] wa, wb, p;
        int s;
        ea = ext_op(a, sg, wd);
        eb = ext_op(b, sg, wd);
        if (!dv) begin
            wa  = sg ? {{64{ea[63]}}, ea} : {64'b0, ea};
            wb  = sg ? {{64{eb[63]}}, eb} : {64'b0, eb};
            p   = wa * wb;
            hi  = wd ? p[127:64] : sx32(p[63:32] & 64'hFFFF_FFFF);
            lo  = wd ? p[63:0]   : sx32(p[63:0]);
            lat = wd ? 6 : 4;
        end else begin
            mag = (sg && ea[63]) ? -ea : ea;
            s   = sigb(mag);
            lat = 9 + ((s > 12) ? s : 12);
            if (eb == 0) begin
                q = '1; r = ea;
            end else if (sg && ea == 64'h8000_0000_0000_0000 && eb == '1) begin
                q = ea; r = '0;
            end else if (sg) begin
                q = $signed(ea) / $signed(eb);
                r = $signed(ea) % $signed(eb);
            end else begin
                q = ea / eb;
                r = ea % eb;
            end
            hi = wd ? r : sx32(r);
            lo = wd ? q : sx32(q);
        end
    endtask

    // Called at a negedge; drives start now and returns at the negedge of the done cycle.
    task automatic run_op(string req, bit dv, bit sg, bit wd, logic [63:0] a, logic [63:0] b);
        logic [63:0] ehi, elo;
        int elat, lat, busy_bad;
        ref_op(dv, sg, wd, a, b, ehi, elo, elat);
        start = 1'b1; op_div = dv; op_signed = sg; op_wide = wd; src_a = a; src_b = b;
        lat = 0; busy_bad = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (!done && !busy) busy_bad++;
        end while (!done && lat < 200);
        chk(req, "latency", 128'(lat), 128'(elat));
        chk("R2", "busy gaps before done", 128'(busy_bad), 128'd0);
        chk("R2", "busy in done cycle", 128'(busy), 128'd0);
        chk(req, "res_hi", 128'(res_hi), 128'(ehi));
        chk(req, "res_lo", 128'(res_lo), 128'(elo));
    endtask

    task automatic t_reset;
        chk("R1", "busy", 128'(busy), 0);
        chk("R1", "done", 128'(done), 0);
        chk("R1", "res_hi", 128'(res_hi), 0);
        chk("R1", "res_lo", 128'(res_lo), 0);
    endtask

    task automatic t_mul;
        run_op("R4", 0, 0, 0, 64'h3, 64'h5);
        run_op("R4", 0, 0, 0, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF);
        run_op("R6", 0, 1, 0, 64'hAAAA_0000_FFFF_FFF9, 64'h3);
        run_op("R6", 0, 1, 0, 64'h8000_0000, 64'h8000_0000);
        run_op("R5", 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R5", 0, 0, 1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        run_op("R6", 0, 1, 1, 64'hFFFF_FFFF_FFFF_FF85, 64'hFFFF_FFFF_FFFF_FFF0);
        run_op("R6", 0, 1, 1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_div;
        run_op("R7", 1, 0, 1, 64'd100, 64'd7);
        run_op("R7", 1, 0, 1, 64'd0, 64'd9);
        run_op("R7", 1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3);
        run_op("R7", 1, 0, 1, 64'h0000_4000_0000_0001, 64'h1_0000);
        run_op("R8", 1, 1, 1, -64'd100, 64'd7);
        run_op("R8", 1, 1, 1, 64'd100, -64'd7);
        run_op("R8", 1, 1, 1, -64'd100, -64'd7);
        run_op("R8", 1, 0, 0, 64'hFFFF_FFFF_8000_0000, 64'd2);
        run_op("R8", 1, 1, 0, 64'h0000_0000_FFFF_FC18, 64'd10);
        run_op("R8", 1, 0, 0, 64'h1234_5678_FFFF_FFFF, 64'h7);
    endtask

    task automatic t_div_edge;
        run_op("R9", 1, 0, 1, 64'd12345, 64'd0);
        run_op("R9", 1, 1, 1, -64'd5, 64'd0);
        run_op("R9", 1, 1, 0, 64'h0000_0000_FFFF_FFFB, 64'hFFFF_FFFF_0000_0000);
        run_op("R10", 1, 1, 1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R10", 1, 1, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic t_ignore_start;
        logic [63:0] ehi, elo;
        int elat, lat, extra;
        ref_op(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, ehi, elo, elat);
        start = 1'b1; op_div = 1'b1; op_signed = 1'b0; op_wide = 1'b1;
        src_a = 64'hFFFF_FFFF_FFFF_FFFF; src_b = 64'd3;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            start = (lat >= 3 && lat <= 5);
            op_div = 1'b0; op_wide = 1'b0; src_a = 64'd2; src_b = 64'd2;
        end while (!done && lat < 200);
        start = 1'b0;
        chk("R3", "latency with start while busy", 128'(lat), 128'(elat));
        chk("R3", "res_hi", 128'(res_hi), 128'(ehi));
        chk("R3", "res_lo", 128'(res_lo), 128'(elo));
        extra = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        chk("R3", "no extra operation", 128'(extra), 0);
    endtask

    task automatic t_hold;
        logic [63:0] h0, l0;
        run_op("R5", 0, 0, 1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        h0 = res_hi; l0 = res_lo;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            src_a = 64'(i * 977); src_b = ~64'(i); op_div = i[0];
        end
        chk("R11", "res_hi held", 128'(res_hi), 128'(h0));
        chk("R11", "res_lo held", 128'(res_lo), 128'(l0));
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mul();
        t_div();
        t_div_edge();
        @(negedge clk);
        t_ignore_start();
        t_hold();
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule